// File: doc/BRIEF.md
# Serial Transmitter with One-Deep Holding Stage

This block turns parallel bytes into an asynchronous serial character stream. A byte written by the host lands in a single holding register. From there it moves into a shift stage, which sends a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The pace comes from a clock enable that pulses sixteen times per bit period. Two status flags tell the host whether the holding register can take a new byte and whether the whole transmitter has gone quiet.

The write side is a plain strobe with no back-pressure. The block accepts every write. A write into a full holding register replaces the byte waiting there, and nothing signals this. Software that wants every byte sent polls the holding-empty flag before it writes. The framing controls (character length, stop bits, parity mode) are sampled when a character moves into the shift stage. The send-break control acts on the line directly and at once. Deciding how long a break lasts is left to software.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, `txd` is 1 (mark), `thr_empty` is 1 and `tsr_empty` is 1.
- R2: A write made while both flags are 1 causes `thr_empty` and `tsr_empty` to read 0 in the cycle after the write edge. On the next edge `thr_empty` returns to 1 and the start bit (0) appears on `txd`, so `thr_empty` is low for exactly one cycle.
- R3: A character is a 0 start bit followed by 5 + `cfg_len` data bits, sent least significant bit first (`cfg_len` 0 gives 5 bits and 3 gives 8). Each bit lasts 16 `tick` pulses.
- R4: With `cfg_par_en` set, one parity bit follows the data bits. With `cfg_par_force` clear, the parity bit is the XOR of the sent data bits when `cfg_par_even` is 1, and its inverse when `cfg_par_even` is 0. With `cfg_par_force` set, the parity bit equals the inverse of `cfg_par_even`.
- R5: The character ends with one stop bit (1), or with two stop bits when `cfg_two_stop` is 1.
- R6: A write made while a character is being shifted and the holding register is empty leaves `thr_empty` at 0. The byte waits and is sent as the next character, after the current character's last stop bit.
- R7: A write into a full holding register replaces the waiting byte. Only the newest byte is sent, the replaced one never appears on `txd`, and no flag reports the loss.
- R8: `tsr_empty` is 1 only when nothing is being shifted and the holding register is empty. It is never 1 while `thr_empty` is 0. It rises one edge after the last stop bit ends if no byte is waiting: for a 10-bit character started by the write at edge E0, it rises at edge E0 + 161.
- R9: While `cfg_break` is 1, `txd` is 0, whether or not a character is in progress. Shifting goes on underneath. When `cfg_break` is cleared, `txd` shows the shift stage's current level again.
- R10: Bit timing counts only `tick` pulses, so with one pulse every three clocks each bit lasts 48 clocks.
- R11: The framing controls are captured when a character enters the shift stage. Changing them during a character affects only later characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| tick | input | 1 | Clock enable, 16 pulses per bit period |
| wr_en | input | 1 | Write strobe for the holding register, never back-pressured |
| wr_data | input | 8 | Byte to send |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_par_en | input | 1 | 1 adds a parity bit |
| cfg_par_even | input | 1 | 1 selects even parity, 0 selects odd |
| cfg_par_force | input | 1 | 1 forces the parity bit to the inverse of `cfg_par_even` |
| cfg_break | input | 1 | 1 holds `txd` at space (0) |
| txd | output | 1 | Serial line, idle high |
| thr_empty | output | 1 | Holding register empty |
| tsr_empty | output | 1 | Transmitter fully idle |

## Verification
The flags are registered. Counted from the write edge, `thr_empty` falls one edge later, the immediate handoff restores it and drives the start bit one edge after that, and `tsr_empty` rises one edge after the final stop bit ends. The bench steps on falling clock edges and checks each of these flags at the exact falling edge that follows the rising edge where it changes. `cfg_break` acts without a register, so the bench checks `txd` at the falling edge right after it changes that control. A monitor waits for the start-bit edge, samples `txd` half a bit later, and then samples once per bit period measured as 16 tick periods. This tolerates the sub-tick offset of a start that was not aligned to a tick, and it compares each whole character against the one the driver queued.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_t;

  typedef struct packed {
    logic [1:0] len;
    logic       two_stop;
    logic       par_en;
    logic       par_even;
    logic       par_force;
  } frame_cfg_t;

endpackage

// File: rtl/uart_tx_bitclk.sv
module uart_tx_bitclk #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  output logic bit_done
);
  localparam int SUB_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);

  logic [SUB_W-1:0] sub_q;

  assign bit_done = tick && (sub_q == SUB_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_q <= '0;
    end else if (restart) begin
      sub_q <= '0;
    end else if (tick) begin
      sub_q <= bit_done ? '0 : sub_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (wr_en) begin
        full <= 1'b1;
        data <= wr_data;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  frame_cfg_t        cfg,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              bit_done,
  output logic              take,
  output logic              line,
  output logic              idle
);
  localparam int MIN_BITS = DATA_W - 3;
  localparam int CNT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  tx_state_t         state_q;
  frame_cfg_t        cfg_q;
  logic [DATA_W-1:0] sr_q;
  logic [CNT_W-1:0]  idx_q;
  logic              stop_q;
  logic              par_q;
  logic [CNT_W-1:0]  last_idx;
  logic              new_par;

  function automatic logic par_of(input logic [DATA_W-1:0] d, input int nbits);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nbits) acc = acc ^ d[i];
    end
    return acc;
  endfunction

  always_comb begin
    logic raw;
    raw = par_of(hold_data, MIN_BITS + int'(cfg.len));
    if (cfg.par_force) new_par = ~cfg.par_even;
    else if (cfg.par_even) new_par = raw;
    else new_par = ~raw;
  end

  assign last_idx = CNT_W'(MIN_BITS - 1) + CNT_W'(cfg_q.len);
  assign take     = (state_q == ST_IDLE) && hold_full;
  assign idle     = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      sr_q    <= '0;
      idx_q   <= '0;
      stop_q  <= 1'b0;
      par_q   <= 1'b0;
      line    <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          line <= 1'b1;
          if (hold_full) begin
            cfg_q   <= cfg;
            sr_q    <= hold_data;
            par_q   <= new_par;
            idx_q   <= '0;
            stop_q  <= 1'b0;
            line    <= 1'b0;
            state_q <= ST_START;
          end
        end
        ST_START: begin
          if (bit_done) begin
            line    <= sr_q[0];
            sr_q    <= sr_q >> 1;
            idx_q   <= '0;
            state_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (bit_done) begin
            if (idx_q == last_idx) begin
              if (cfg_q.par_en) begin
                line    <= par_q;
                state_q <= ST_PARITY;
              end else begin
                line    <= 1'b1;
                stop_q  <= 1'b0;
                state_q <= ST_STOP;
              end
            end else begin
              line  <= sr_q[0];
              sr_q  <= sr_q >> 1;
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_PARITY: begin
          if (bit_done) begin
            line    <= 1'b1;
            stop_q  <= 1'b0;
            state_q <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (bit_done) begin
            if (cfg_q.two_stop && !stop_q) begin
              stop_q <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_two_stop,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_par_force,
  input  logic              cfg_break,
  output logic              txd,
  output logic              thr_empty,
  output logic              tsr_empty
);
  frame_cfg_t        cfg;
  logic              take;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              bit_done;
  logic              line;
  logic              shift_idle;

  assign cfg = '{len: cfg_len, two_stop: cfg_two_stop, par_en: cfg_par_en,
                 par_even: cfg_par_even, par_force: cfg_par_force};

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .take   (take),
    .full   (hold_full),
    .data   (hold_data)
  );

  uart_tx_bitclk #(.OVERSAMPLE(OVERSAMPLE)) u_bitclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .restart (take),
    .bit_done(bit_done)
  );

  uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg),
    .hold_full(hold_full),
    .hold_data(hold_data),
    .bit_done (bit_done),
    .take     (take),
    .line     (line),
    .idle     (shift_idle)
  );

  assign txd       = cfg_break ? 1'b0 : line;
  assign thr_empty = ~hold_full;
  assign tsr_empty = shift_idle & ~hold_full;
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic cfg_break,
  input logic txd,
  input logic thr_empty,
  input logic tsr_empty
);
  p_break_space_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_break |-> !txd);

  p_idle_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tsr_empty && !cfg_break) |-> txd);

  p_tsr_needs_thr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tsr_empty |-> thr_empty);

  p_thr_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(thr_empty) && $past(tsr_empty)) |=> thr_empty);

  p_write_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !thr_empty);

  p_write_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tsr_empty);
endmodule

bind uart_tx_core uart_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .cfg_break(cfg_break),
  .txd      (txd),
  .thr_empty(thr_empty),
  .tsr_empty(tsr_empty)
);

// File: tb/uart_tx_core_bench.sv
module uart_tx_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_two_stop = 1'b0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       cfg_par_force = 1'b0;
  logic       cfg_break = 1'b0;
  logic       txd, thr_empty, tsr_empty;

  int checks = 0;
  int errors = 0;
  int tick_div = 1;
  int tick_cnt = 0;
  logic mon_en = 1'b0;
  bit   done = 1'b0;
  logic [15:0] exp_bits[$];
  int          exp_len[$];

  uart_tx_core u_uart_tx_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_len(cfg_len), .cfg_two_stop(cfg_two_stop), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .cfg_par_force(cfg_par_force),
    .cfg_break(cfg_break), .txd(txd), .thr_empty(thr_empty), .tsr_empty(tsr_empty)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (tick_cnt >= tick_div - 1) begin
      tick_cnt <= 0;
      tick     <= 1'b1;
    end else begin
      tick_cnt <= tick_cnt + 1;
      tick     <= 1'b0;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // driver side: expected character from the current settings (R3 R4 R5)
  task automatic push_expected(input logic [7:0] d);
    logic [15:0] b;
    int n;
    logic p;
    b = '0;
    n = 0;
    p = 1'b0;
    b[n] = 1'b0; n++;
    for (int i = 0; i < 5 + int'(cfg_len); i++) begin
      b[n] = d[i]; p = p ^ d[i]; n++;
    end
    if (cfg_par_en) begin
      b[n] = cfg_par_force ? ~cfg_par_even : (cfg_par_even ? p : ~p); n++;
    end
    b[n] = 1'b1; n++;
    if (cfg_two_stop) begin b[n] = 1'b1; n++; end
    exp_bits.push_back(b);
    exp_len.push_back(n);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] len, input logic two, input logic pen,
                         input logic even, input logic force_p);
    cfg_len = len; cfg_two_stop = two; cfg_par_en = pen;
    cfg_par_even = even; cfg_par_force = force_p;
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] len, input logic two,
                      input logic pen, input logic even, input logic force_p);
    while (!thr_empty) @(negedge clk);
    set_cfg(len, two, pen, even, force_p);
    push_expected(d);
    wr(d);
  endtask

  task automatic wait_idle();
    while (!tsr_empty) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  // monitor: catches each character and compares it with the queue
  task automatic catch_frame();
    logic [15:0] got;
    logic [15:0] exp;
    int n;
    got = '0;
    if (exp_len.size() == 0) begin
      n = 10;
      exp = 16'hFFFF;
    end else begin
      n = exp_len.pop_front();
      exp = exp_bits.pop_front();
    end
    repeat (8 * tick_div) @(negedge clk);
    got[0] = txd;
    for (int k = 1; k < n; k++) begin
      repeat (16 * tick_div) @(negedge clk);
      got[k] = txd;
    end
    check("R3 R4 R5 R10 R11 character", got, exp);
  endtask

  initial begin
    logic prev;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (!mon_en || !rst_n) prev = 1'b1;
      else if (prev && !txd) begin
        catch_frame();
        prev = txd;
      end else prev = txd;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 txd", 16'(txd), 16'd1);
    check("R1 thr_empty", 16'(thr_empty), 16'd1);
    check("R1 tsr_empty", 16'(tsr_empty), 16'd1);
    mon_en = 1'b1;

    // R2 immediate handoff and R8 end-of-character timing, 8 data bits, 1 stop
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    push_expected(8'hA5);
    wr(8'hA5);
    check("R2 thr_empty after write", 16'(thr_empty), 16'd0);
    check("R2 tsr_empty after write", 16'(tsr_empty), 16'd0);
    check("R2 line still mark", 16'(txd), 16'd1);
    @(negedge clk);
    check("R2 thr_empty restored", 16'(thr_empty), 16'd1);
    check("R2 start bit", 16'(txd), 16'd0);
    repeat (159) @(negedge clk);
    check("R8 tsr_empty before end", 16'(tsr_empty), 16'd0);
    @(negedge clk);
    check("R8 tsr_empty at end", 16'(tsr_empty), 16'd1);
    wait_idle();

    // R3 R4 R5 R11 sweep: settings change while the previous character shifts
    send(8'h3C, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    send(8'h17, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0);
    send(8'h6B, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0);
    send(8'hC3, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0);
    send(8'h81, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0);
    send(8'h5A, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1);
    send(8'h5A, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1);
    send(8'hFE, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    send(8'h00, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0);
    wait_idle();

    // R6 waiting byte, R7 overwrite of the waiting byte
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    push_expected(8'h11);
    wr(8'h11);
    repeat (2) @(negedge clk);
    wr(8'h22);
    check("R6 thr_empty while waiting", 16'(thr_empty), 16'd0);
    repeat (20) @(negedge clk);
    check("R6 byte still waiting", 16'(thr_empty), 16'd0);
    push_expected(8'h33);
    wr(8'h33);
    check("R7 no flag on overwrite", 16'(thr_empty), 16'd0);
    wait_idle();

    // R10 sparse ticks
    tick_div = 3;
    repeat (6) @(negedge clk);
    send(8'h96, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0);
    send(8'h2D, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    wait_idle();
    tick_div = 1;
    repeat (6) @(negedge clk);

    // R9 break forces space, shifting continues underneath
    mon_en = 1'b0;
    cfg_break = 1'b1;
    @(negedge clk);
    check("R9 break while idle", 16'(txd), 16'd0);
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    wr(8'hFF);
    repeat (40) @(negedge clk);
    check("R9 break during character", 16'(txd), 16'd0);
    check("R9 shifting continues", 16'(tsr_empty), 16'd0);
    cfg_break = 1'b0;
    @(negedge clk);
    check("R9 release shows data bit", 16'(txd), 16'd1);
    wait_idle();
    check("R9 idle mark after break", 16'(txd), 16'd1);
    mon_en = 1'b1;

    check("R7 all queued characters seen", 16'(exp_len.size()), 16'd0);
    finish_run();
  end
endmodule